// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor's load/store unit and a lower-level memory. It serves one 32-bit word access per cycle. By default it holds 16 KiB as 256 lines of 16 words. Each line is found from its address alone: one stored tag and one valid bit per line decide whether the access is a hit. Read hits answer in the cycle after the request is accepted. On a read miss the cache raises its stall output, fetches the whole line from memory as a burst of words, installs the line, and then runs the read again so that it completes as a hit.

Every store is written through to memory by way of a one-entry write buffer, so the processor does not wait for memory on a store. A store that hits also updates the cached word. A store that misses leaves the cache untouched. Before a line fetch starts, any buffered store is sent out to memory, so a fetch never returns data older than a store the processor has already made. The requester holds its request steady while the stall output is high. A request is taken on any clock edge where it is present and the stall output is low.

Top module: `dmc_wt_cache`

## Requirements
- R1: A byte address is split, from the top down, into a tag (18 bits by default), a line index (8 bits), a word-in-line select (4 bits) and a 2-bit byte offset. The byte offset has no effect on which word is read, and memory write addresses are sent with those two bits cleared.
- R2: A read is a hit when the indexed line is valid and its stored tag equals the request tag. A hit returns the stored word with `cpu_rvalid` high in the cycle after acceptance, and `cpu_stall` is low in that cycle.
- R3: A read miss holds `cpu_stall` high and raises `mem_rd_req` with a line-aligned `mem_rd_addr`. `mem_rd_req` stays high until the last of the line's words has been taken on `mem_rd_valid`. The read then completes with the word that memory returned. There is exactly one fetch per read miss.
- R4: A fill writes every word of the line, stores the tag and sets the valid bit, so later reads to any word of that line hit.
- R5: Two addresses with the same index and different tags evict each other, so reads that alternate between them all miss.
- R6: Every accepted write produces exactly one memory write, carrying its word address and data, with the writes in acceptance order.
- R7: A write is accepted without stall when the write buffer is empty. `mem_wr_req` and its address and data stay unchanged until `mem_wr_done`. A write that must enter the buffer while the buffer is occupied stalls until the entry is released.
- R8: A write hit updates the cached word, and a read of that word accepted in the very next cycle returns the new value.
- R9: A write miss allocates no line, so the next read to that line misses.
- R10: A line fetch never starts while a buffered write is pending: `mem_wr_req` is low whenever `mem_rd_req` rises.
- R11: A synchronous reset clears all valid bits and empties the write buffer. After reset, `cpu_stall`, `cpu_rvalid`, `mem_rd_req` and `mem_wr_req` are low, and the first read of any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_stall | output | 1 | Request not taken this cycle |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 32 | Read data |
| mem_rd_req | output | 1 | Line fetch in progress |
| mem_rd_addr | output | 32 | Line-aligned fetch address |
| mem_rd_valid | input | 1 | One fetched word present |
| mem_rd_data | input | 32 | Fetched word, in ascending order |
| mem_wr_req | output | 1 | Buffered write pending |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_done | input | 1 | Memory has completed the write |

## Verification
A wrong tag or valid bit shows up in the very next response. A hit that should have been a miss answers one cycle after acceptance with a stale word. A false miss raises an extra fetch and delays the answer by at least the memory latency plus one line. A lost write-hit update, or a missing bypass, returns old data on the back-to-back read. A mis-ordered drain shows up as a fetch that starts while a write is pending, or as stale data after a refill. Reads that cycle through every word and every conflicting tag of a small configuration expose each of these within a handful of accesses.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_FILL   = 2'd2,
    ST_REPLAY = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 256,
  parameter int TAG_W = 18,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             valid_q,
  output logic [TAG_W-1:0] tag_q
);
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] vbits;

  // tag array: plain synchronous RAM, no reset
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en) tag_q <= tag_mem[rd_idx];
  end

  // valid bits live in flops so reset can clear them in one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      vbits   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (wr_en) vbits[wr_idx] <= 1'b1;
      if (rd_en) valid_q <= vbits[rd_idx];
    end
  end
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int DEPTH  = 4096,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dmc_wbuf.sv
module dmc_wbuf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              done,
  output logic              full,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  logic ent_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= 1'b0;
    end else if (push) begin
      ent_v <= 1'b1;
    end else if (done) begin
      ent_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      out_addr <= push_addr;
      out_data <= push_data;
    end
  end

  assign full = ent_v;
endmodule

// File: rtl/dmc_wt_cache.sv
module dmc_wt_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 256,
  parameter int WORDS  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_done
);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int OFF_W   = $clog2(WORDS);
  localparam int IDX_W   = $clog2(LINES);
  localparam int DIX_W   = IDX_W + OFF_W;
  localparam int LOW_W   = OFF_W + BYTE_W;
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W - BYTE_W;
  localparam int WA_W    = ADDR_W - BYTE_W;
  localparam int DEPTH   = LINES * WORDS;

  dmc_state_e state;

  // request stage: word address kept, byte offset dropped
  logic              s1_v;
  logic              s1_we;
  logic [WA_W-1:0]   s1_wa;
  logic [DATA_W-1:0] s1_wdata;

  logic [TAG_W-1:0]  s1_tag;
  logic [IDX_W-1:0]  s1_idx;
  logic [OFF_W-1:0]  s1_off;
  logic [DIX_W-1:0]  s1_dix;
  logic [IDX_W-1:0]  in_idx;
  logic [DIX_W-1:0]  in_dix;
  logic              unused_byte_bits;

  assign s1_tag = s1_wa[DIX_W +: TAG_W];
  assign s1_idx = s1_wa[OFF_W +: IDX_W];
  assign s1_off = s1_wa[OFF_W-1:0];
  assign s1_dix = s1_wa[DIX_W-1:0];
  assign in_idx = cpu_addr[LOW_W +: IDX_W];
  assign in_dix = cpu_addr[BYTE_W +: DIX_W];
  assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

  logic              valid_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] ram_q;
  logic              wb_full;

  logic in_idle, hit, done, stall, accept, commit, wr_hit;
  logic replay_rd, rd_en, fill_we, fill_last;
  logic [OFF_W-1:0]  fill_cnt;
  logic              fwd_v;
  logic [DATA_W-1:0] fwd_data;

  assign in_idle   = (state == ST_IDLE);
  assign replay_rd = (state == ST_REPLAY);
  assign hit       = valid_q && (tag_q == s1_tag);
  assign done      = s1_v && in_idle && (s1_we ? !wb_full : hit);
  assign stall     = !in_idle || (s1_v && !done);
  assign accept    = cpu_req && !stall;
  assign commit    = done && s1_we;
  assign wr_hit    = commit && hit;
  assign rd_en     = accept || replay_rd;
  assign fill_we   = (state == ST_FILL) && mem_rd_valid;
  assign fill_last = fill_we && (fill_cnt == OFF_W'(WORDS - 1));

  // request stage register
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
    end else if (accept) begin
      s1_v <= 1'b1;
    end else if (done) begin
      s1_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_we    <= cpu_we;
      s1_wa    <= cpu_addr[ADDR_W-1:BYTE_W];
      s1_wdata <= cpu_wdata;
    end
  end

  // miss sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:   if (s1_v && !s1_we && !hit) state <= wb_full ? ST_DRAIN : ST_FILL;
        ST_DRAIN:  if (!wb_full) state <= ST_FILL;
        ST_FILL:   if (fill_last) state <= ST_REPLAY;
        ST_REPLAY: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || state != ST_FILL) begin
      fill_cnt <= '0;
    end else if (fill_we) begin
      fill_cnt <= fill_cnt + 1'b1;
    end
  end

  // bypass for a read of the word written by the preceding write hit
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_v <= 1'b0;
    end else if (rd_en) begin
      fwd_v <= wr_hit && accept && (in_dix == s1_dix);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hit) fwd_data <= s1_wdata;
  end

  dmc_tag_store #(
    .LINES (LINES),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_idx  (replay_rd ? s1_idx : in_idx),
    .wr_en   (fill_last),
    .wr_idx  (s1_idx),
    .wr_tag  (s1_tag),
    .valid_q (valid_q),
    .tag_q   (tag_q)
  );

  dmc_data_store #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_data (
    .clk   (clk),
    .we    (fill_we || wr_hit),
    .waddr (fill_we ? {s1_idx, fill_cnt} : {s1_idx, s1_off}),
    .wdata (fill_we ? mem_rd_data : s1_wdata),
    .re    (rd_en),
    .raddr (replay_rd ? s1_dix : in_dix),
    .rdata (ram_q)
  );

  dmc_wbuf #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .push      (commit),
    .push_addr ({s1_wa, {BYTE_W{1'b0}}}),
    .push_data (s1_wdata),
    .done      (mem_wr_done),
    .full      (wb_full),
    .out_addr  (mem_wr_addr),
    .out_data  (mem_wr_data)
  );

  assign cpu_stall   = stall;
  assign cpu_rvalid  = done && !s1_we;
  assign cpu_rdata   = fwd_v ? fwd_data : ram_q;
  assign mem_rd_req  = (state == ST_FILL);
  assign mem_rd_addr = {s1_wa[WA_W-1:OFF_W], {LOW_W{1'b0}}};
  assign mem_wr_req  = wb_full;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LOW_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_stall,
  input logic              cpu_rvalid,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              mem_wr_done
);
  AST_FETCH_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_req) |-> !mem_wr_req); // R10

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (mem_rd_addr[LOW_W-1:0] == '0)); // R3

  AST_FETCH_STALLS: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> cpu_stall); // R3

  AST_WR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |-> (mem_wr_addr[1:0] == 2'b00)); // R1

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && !mem_wr_done) |=>
      (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R7

  AST_RVALID_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> !cpu_stall); // R2

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_rd_req && !mem_wr_req && !cpu_rvalid)); // R11
endmodule

bind dmc_wt_cache dmc_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LOW_W  (LOW_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_stall   (cpu_stall),
  .cpu_rvalid  (cpu_rvalid),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .mem_wr_req  (mem_wr_req),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .mem_wr_done (mem_wr_done)
);

// File: tb/sim_dmc_wt_cache.sv
`timescale 1ns/1ps
module sim_dmc_wt_cache;
  localparam int LINES = 4;
  localparam int WORDS = 4;
  localparam int NW    = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_stall, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_rd_req, mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_addr, mem_rd_data = '0;
  logic        mem_wr_req, mem_wr_done = 1'b0;
  logic [31:0] mem_wr_addr, mem_wr_data;

  always #2 clk = ~clk;

  dmc_wt_cache #(.ADDR_W(32), .DATA_W(32), .LINES(LINES), .WORDS(WORDS)) u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_done(mem_wr_done));

  int nchk = 0, nfail = 0, cyc = 0, fetches = 0, pred_miss = 0;
  int rd_lat = 2, wr_lat = 1;
  logic [31:0] mem_model [NW];
  logic [31:0] ref_mem [NW];
  bit bv [LINES];
  int btag [LINES];
  logic [31:0] rq_data [64];
  bit          rq_hit [64];
  int          rq_acc [64];
  string       rq_req [64];
  int rh = 0, rt = 0;
  logic [31:0] wq_addr [64];
  logic [31:0] wq_data [64];
  int wh = 0, wt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // memory model: drives its outputs at the falling edge
  bit rd_act = 0, wr_busy = 0;
  int rd_cnt = 0, rd_beat = 0, rd_base = 0, wr_cnt = 0;
  always @(negedge clk) begin
    if (rst) begin
      rd_act = 0; wr_busy = 0; mem_rd_valid = 0; mem_wr_done = 0;
    end else begin
      mem_wr_done = 0;
      if (!rd_act && mem_rd_req) begin
        rd_act = 1; rd_cnt = rd_lat; rd_beat = 0;
        rd_base = int'(mem_rd_addr[7:2]);
        fetches++;
        check(!mem_wr_req, "R10", 32'(mem_wr_req), 32'd0);
        check(mem_rd_addr[3:0] == 4'd0, "R3", mem_rd_addr, mem_rd_addr & ~32'hF);
      end
      if (rd_act) begin
        if (rd_beat == WORDS) begin
          mem_rd_valid = 0; rd_act = 0;
        end else if (rd_cnt > 0) begin
          rd_cnt--; mem_rd_valid = 0;
        end else begin
          mem_rd_valid = 1; mem_rd_data = mem_model[rd_base + rd_beat]; rd_beat++;
        end
      end
      if (mem_wr_req && !wr_busy) begin
        wr_busy = 1; wr_cnt = wr_lat;
      end
      if (wr_busy) begin
        if (wr_cnt > 0) wr_cnt--;
        else begin
          mem_wr_done = 1; wr_busy = 0;
          mem_model[mem_wr_addr[7:2]] = mem_wr_data;
          if (wh == wt) check(0, "R6", mem_wr_addr, 32'hFFFFFFFF);
          else begin
            check(mem_wr_addr == wq_addr[wh] && mem_wr_data == wq_data[wh], "R6",
                  mem_wr_addr ^ mem_wr_data, wq_addr[wh] ^ wq_data[wh]);
            wh = (wh + 1) % 64;
          end
        end
      end
    end
  end

  // read response monitor
  always @(negedge clk) begin
    if (!rst && cpu_rvalid) begin
      if (rh == rt) check(0, "R2", cpu_rdata, 32'hFFFFFFFF);
      else begin
        check(cpu_rdata == rq_data[rh], rq_req[rh], cpu_rdata, rq_data[rh]);
        if (rq_hit[rh]) check(cyc == rq_acc[rh], "R2", 32'(cyc), 32'(rq_acc[rh]));
        else check(cyc >= rq_acc[rh] + rd_lat + WORDS, "R3", 32'(cyc), 32'(rq_acc[rh] + rd_lat + WORDS));
        rh = (rh + 1) % 64;
      end
    end
  end

  // one access; called just after a falling edge, returns after the next one
  task automatic issue(input bit we, input int a, input logic [31:0] d, input string rq, output int stalls);
    int w, ix, tg;
    bit h;
    cpu_req = 1; cpu_we = we; cpu_addr = 32'(a); cpu_wdata = d; stalls = 0;
    while (cpu_stall) begin @(negedge clk); stalls++; end
    w = (a >> 2) % NW; ix = (a >> 4) % LINES; tg = a >> 6;
    if (we) begin
      ref_mem[w] = d;
      wq_addr[wt] = 32'(a) & ~32'h3; wq_data[wt] = d; wt = (wt + 1) % 64;
    end else begin
      h = bv[ix] && btag[ix] == tg;
      if (!h) begin bv[ix] = 1; btag[ix] = tg; pred_miss++; end
      rq_data[rt] = ref_mem[w]; rq_hit[rt] = h; rq_acc[rt] = cyc + 1; rq_req[rt] = rq;
      rt = (rt + 1) % 64;
    end
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (cpu_stall || mem_wr_req || mem_rd_req || rh != rt || wh != wt) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R3 act=%h exp=%h", 32'(cyc), 32'd0);
    report();
    $finish;
  end

  initial begin
    int s, f0;
    logic [31:0] lcg;
    for (int i = 0; i < NW; i++) begin
      mem_model[i] = 32'h5A5A0000 ^ (32'(i) * 32'h9E3779B9);
      ref_mem[i] = mem_model[i];
    end
    for (int i = 0; i < LINES; i++) begin bv[i] = 0; btag[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!cpu_stall && !cpu_rvalid && !mem_rd_req && !mem_wr_req, "R11",
          {28'd0, cpu_stall, cpu_rvalid, mem_rd_req, mem_wr_req}, 32'd0);

    // R4 R5: ascending sweep over every word and every tag
    for (int w = 0; w < NW; w++) issue(0, w * 4, '0, "R4", s);
    settle();
    // R1: descending sweep with nonzero byte offsets
    for (int w = NW - 1; w >= 0; w--) issue(0, w * 4 + (w % 4), '0, "R1", s);
    settle();
    // R5: ping-pong between two tags on line 0
    for (int k = 0; k < 6; k++) issue(0, (k % 2) ? 32'h40 : 32'h00, '0, "R5", s);
    settle();

    // R8: write hit followed at once by a read of the same word
    issue(0, 32'h10, '0, "R8", s);
    issue(1, 32'h14, 32'hDEAD0001, "R8", s);
    issue(0, 32'h14, '0, "R8", s);
    issue(1, 32'h1B, 32'hDEAD0002, "R8", s);
    @(negedge clk);
    issue(0, 32'h18, '0, "R8", s);
    settle();

    // R9: write miss, no allocation; next read fetches
    f0 = fetches;
    issue(1, 32'h88, 32'hBEEF0009, "R9", s);
    issue(0, 32'h88, '0, "R9", s);
    settle();
    check(fetches == f0 + 1, "R9", 32'(fetches - f0), 32'd1);

    // R7: write buffer occupancy stall
    wr_lat = 6;
    issue(1, 32'h20, 32'h77770001, "R7", s);
    check(s == 0, "R7", 32'(s), 32'd0);
    issue(1, 32'h24, 32'h77770002, "R7", s);
    check(s == 0, "R7", 32'(s), 32'd0);
    issue(1, 32'h28, 32'h77770003, "R7", s);
    check(s >= wr_lat - 1, "R7", 32'(s), 32'(wr_lat - 1));
    settle();

    // mixed traffic under several latencies
    lcg = 32'h1234567;
    for (int ph = 0; ph < 4; ph++) begin
      rd_lat = (ph * 5) % 8; wr_lat = (ph * 3 + 1) % 5;
      for (int k = 0; k < 120; k++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        if (lcg[20:19] == 2'b00) issue(1, int'(lcg[29:24]) * 4 + int'(lcg[1:0]), lcg, "R6", s);
        else issue(0, int'(lcg[29:24]) * 4, '0, "R2", s);
        if (lcg[15]) @(negedge clk);
      end
      settle();
    end
    check(fetches == pred_miss, "R3", 32'(fetches), 32'(pred_miss));

    // R11: reset with a write pending (same value, so memory stays consistent)
    wr_lat = 30;
    issue(1, 32'h30, ref_mem[12], "R11", s);
    repeat (2) @(negedge clk);
    rst = 1;
    for (int i = 0; i < LINES; i++) bv[i] = 0;
    wh = 0; wt = 0; rh = 0; rt = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!cpu_stall && !cpu_rvalid && !mem_rd_req && !mem_wr_req, "R11",
          {28'd0, cpu_stall, cpu_rvalid, mem_rd_req, mem_wr_req}, 32'd0);
    wr_lat = 1;
    f0 = fetches;
    issue(0, 32'h00, '0, "R11", s);
    settle();
    check(fetches == f0 + 1, "R11", 32'(fetches - f0), 32'd1);

    report();
    $finish;
  end
endmodule